// File: doc/BRIEF.md
# Four-Beat Burst Memory with Split Read and Write Ports

This block is a synthesizable memory with one read data port and one write data port. Every access moves a burst of four data words. Two of those words pass per clock cycle, carried as a rise lane and a fall lane of a double-width bus. On each clock edge the block samples two active-low selects, one for reading and one for writing, and one block address. Reads and writes are sequenced independently, so a burst on one port can overlap a burst on the other.

A write delivers its first two words in the cycle its command is sampled and its last two in the next cycle. A read places its words on the output lanes in the two cycles after its command. A registered output-enable tells the surrounding pad logic when the read lanes carry data. Between bursts it stands for the high-impedance state, and the lanes are held at zero then.

Top module: `qburst_sram`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `rdata_oe` is 0, both read lanes are 0 and no burst is pending on either port.
- R2: A write accepted at edge n stores the rise lane as word 0 and the fall lane as word 1 of the addressed block, both taken from cycle n. It stores the rise lane as word 2 and the fall lane as word 3, both taken from cycle n+1.
- R3: A read accepted at edge n drives word 0 on the rise lane and word 1 on the fall lane after edge n+1. It drives word 2 on the rise lane and word 3 on the fall lane after edge n+2. `rdata_oe` is 1 in both cycles.
- R4: A low read select in the cycle right after an accepted read is ignored and starts no burst.
- R5: A low write select in the cycle right after an accepted write is ignored. The address of that cycle has no effect, and its lanes become words 2 and 3 of the earlier write.
- R6: A read accepted two edges after an earlier read streams its words straight after the earlier burst, and `rdata_oe` stays 1 through all four cycles.
- R7: A write accepted one edge after a read, or a read accepted one edge after a write, completes with correct data on both ports.
- R8: A read captures the stored contents of its 4-word block at its command edge. A write to that block accepted at the same edge does not appear in the read data. A write to that block accepted one edge earlier appears in words 0 and 1 only.
- R9: When no read is accepted at two consecutive edges m and m+1, `rdata_oe` is 0 after edge m+2.
- R10: Whenever `rdata_oe` is 0, both read lanes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_n | input | 1 | Read select, active low |
| wr_n | input | 1 | Write select, active low |
| addr | input | ADDR_W | Block address, valid in the command cycle |
| wdata_rise | input | DATA_W | Write lane for words 0 and 2 |
| wdata_fall | input | DATA_W | Write lane for words 1 and 3 |
| rdata_rise | output | DATA_W | Read lane for words 0 and 2 |
| rdata_fall | output | DATA_W | Read lane for words 1 and 3 |
| rdata_oe | output | 1 | Read lanes driven (1) or high-impedance (0) |

## Verification
A read command and the second half of a write can fall on the same edge, and so can a write command and the second half of a read. The bench provokes both by issuing the commands one cycle apart, in each order. It judges the result from the read lanes during the burst and from a later read-back of the written block. It also issues a write and a read to the same block at the same edge, and again one edge apart. There it expects fully old data in the first case, and new words 0 and 1 with old words 2 and 3 in the second.

// File: rtl/qb_pkg.sv
package qb_pkg;
  localparam int unsigned QB_BEATS     = 4;
  localparam int unsigned QB_PER_CYCLE = 2;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_FIRST  = 2'd1,
    RD_SECOND = 2'd2
  } rd_phase_t;
endpackage

// File: rtl/qb_bank.sv
module qb_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual-port, read returns the value held before a same-edge write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qb_ctrl.sv
module qb_ctrl #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_go,
  output logic              wr_go,
  output logic              wr_tail,
  output logic [ADDR_W-1:0] tail_addr
);
  logic rd_busy;

  // a port is blocked for one cycle after it accepts a command
  assign rd_go = !rst && !rd_n && !rd_busy;
  assign wr_go = !rst && !wr_n && !wr_tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_busy   <= 1'b0;
      wr_tail   <= 1'b0;
      tail_addr <= '0;
    end else begin
      rd_busy <= rd_go;
      wr_tail <= wr_go;
      if (wr_go) tail_addr <= addr;
    end
  end
endmodule

// File: rtl/qb_rdpipe.sv
module qb_rdpipe
  import qb_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_go,
  input  logic [QB_BEATS-1:0][DATA_W-1:0]  snap,
  output logic [DATA_W-1:0]                rdata_rise,
  output logic [DATA_W-1:0]                rdata_fall,
  output logic                             rdata_oe
);
  rd_phase_t phase, phase_nx;

  always_comb begin
    if (rd_go)                phase_nx = RD_FIRST;
    else if (phase == RD_FIRST) phase_nx = RD_SECOND;
    else                      phase_nx = RD_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= RD_IDLE;
      rdata_rise <= '0;
      rdata_fall <= '0;
      rdata_oe   <= 1'b0;
    end else begin
      phase <= phase_nx;
      unique case (phase)
        RD_FIRST: begin
          rdata_rise <= snap[0];
          rdata_fall <= snap[1];
          rdata_oe   <= 1'b1;
        end
        RD_SECOND: begin
          rdata_rise <= snap[2];
          rdata_fall <= snap[3];
          rdata_oe   <= 1'b1;
        end
        default: begin
          rdata_rise <= '0;
          rdata_fall <= '0;
          rdata_oe   <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/qburst_sram.sv
module qburst_sram
  import qb_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata_rise,
  input  logic [DATA_W-1:0] wdata_fall,
  output logic [DATA_W-1:0] rdata_rise,
  output logic [DATA_W-1:0] rdata_fall,
  output logic              rdata_oe
);
  logic              rd_go;
  logic              wr_go;
  logic              wr_tail;
  logic [ADDR_W-1:0] tail_addr;
  logic [QB_BEATS-1:0][DATA_W-1:0] snap;

  qb_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr      (addr),
    .rd_go     (rd_go),
    .wr_go     (wr_go),
    .wr_tail   (wr_tail),
    .tail_addr (tail_addr)
  );

  // one bank per word of a block; the first half of a burst fills words 0..1
  for (genvar w = 0; w < QB_BEATS; w++) begin : g_bank
    logic              b_we;
    logic [ADDR_W-1:0] b_waddr;
    logic [DATA_W-1:0] b_wdata;

    if (w < QB_PER_CYCLE) begin : g_head
      assign b_we    = wr_go;
      assign b_waddr = addr;
    end else begin : g_tail
      assign b_we    = wr_tail;
      assign b_waddr = tail_addr;
    end

    if (w % QB_PER_CYCLE == 0) begin : g_rise
      assign b_wdata = wdata_rise;
    end else begin : g_fall
      assign b_wdata = wdata_fall;
    end

    qb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk   (clk),
      .we    (b_we),
      .waddr (b_waddr),
      .wdata (b_wdata),
      .re    (rd_go),
      .raddr (addr),
      .rdata (snap[w])
    );
  end

  qb_rdpipe #(.DATA_W(DATA_W)) u_rdpipe (
    .clk        (clk),
    .rst        (rst),
    .rd_go      (rd_go),
    .snap       (snap),
    .rdata_rise (rdata_rise),
    .rdata_fall (rdata_fall),
    .rdata_oe   (rdata_oe)
  );
endmodule

// File: rtl/qburst_sram_chk.sv
module qburst_sram_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_go,
  input logic              wr_go,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata_rise,
  input logic [DATA_W-1:0] rdata_fall
);
  // R3
  rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |-> ##2 rdata_oe ##1 rdata_oe);

  // R4
  rd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    rd_go |=> !rd_go);

  // R5
  wr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !wr_go);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_go ##1 !rd_go) |=> ##1 !rdata_oe);

  // R10
  quiet_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata_rise == '0 && rdata_fall == '0));
endmodule

bind qburst_sram qburst_sram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_go      (rd_go),
  .wr_go      (wr_go),
  .rdata_oe   (rdata_oe),
  .rdata_rise (rdata_rise),
  .rdata_fall (rdata_fall)
);

// File: tb/qburst_sram_tb.sv
module qburst_sram_tb;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rd_n = 1'b1;
  logic          wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata_rise = '0;
  logic [DW-1:0] wdata_fall = '0;
  logic [DW-1:0] rdata_rise;
  logic [DW-1:0] rdata_fall;
  logic          rdata_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0] model [64][4];

  always #10 clk = ~clk;

  qburst_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wdata_rise(wdata_rise), .wdata_fall(wdata_fall),
    .rdata_rise(rdata_rise), .rdata_fall(rdata_fall), .rdata_oe(rdata_oe)
  );

  function automatic logic [DW-1:0] pat(int blk, int word, int salt);
    return DW'((salt << 8) | (blk << 2) | word);
  endfunction

  task automatic tick(bit rn, bit wn, int a, logic [DW-1:0] r, logic [DW-1:0] f);
    @(negedge clk);
    rd_n = rn; wr_n = wn; addr = AW'(a); wdata_rise = r; wdata_fall = f;
  endtask

  task automatic idle();
    tick(1'b1, 1'b1, 0, '0, '0);
  endtask

  task automatic chk(string tag, bit eo, logic [DW-1:0] er, logic [DW-1:0] ef);
    checks++;
    if (rdata_oe !== eo || rdata_rise !== er || rdata_fall !== ef) begin
      fails++;
      $display("FAIL %s: oe=%0b rise=%h fall=%h expected oe=%0b rise=%h fall=%h",
               tag, rdata_oe, rdata_rise, rdata_fall, eo, er, ef);
    end
  endtask

  task automatic write_blk(int a, int salt);
    tick(1'b1, 1'b0, a, pat(a, 0, salt), pat(a, 1, salt));
    tick(1'b1, 1'b1, 0, pat(a, 2, salt), pat(a, 3, salt));
    for (int w = 0; w < 4; w++) model[a][w] = pat(a, w, salt);
  endtask

  // read a block and check both halves and the release (R3, R9, R10)
  task automatic read_blk(int a, string tag);
    tick(1'b0, 1'b1, a, '0, '0);
    idle();
    idle();
    chk({tag, " R3 words0-1"}, 1'b1, model[a][0], model[a][1]);
    idle();
    chk({tag, " R3 words2-3"}, 1'b1, model[a][2], model[a][3]);
    idle();
    chk({tag, " R9 R10 release"}, 1'b0, '0, '0);
  endtask

  task automatic t_reset();
    rst = 1'b1; rd_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 during reset", 1'b0, '0, '0);
    rst = 1'b0; rd_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 1'b0, '0, '0);
  endtask

  task automatic t_basic();
    write_blk(5, 1);
    write_blk(9, 2);
    read_blk(5, "R2 basic blk5");
    read_blk(9, "R2 basic blk9");
  endtask

  task automatic t_wr_gap();
    tick(1'b1, 1'b0, 12, pat(12, 0, 3), pat(12, 1, 3));
    tick(1'b1, 1'b0, 9, pat(12, 2, 3), pat(12, 3, 3));
    idle();
    for (int w = 0; w < 4; w++) model[12][w] = pat(12, w, 3);
    read_blk(9, "R5 ignored write target");
    read_blk(12, "R5 tail words");
  endtask

  task automatic t_rd_gap();
    tick(1'b0, 1'b1, 5, '0, '0);
    tick(1'b0, 1'b1, 12, '0, '0);
    idle();
    chk("R4 first half", 1'b1, model[5][0], model[5][1]);
    idle();
    chk("R4 second half", 1'b1, model[5][2], model[5][3]);
    idle();
    chk("R4 no second burst", 1'b0, '0, '0);
  endtask

  task automatic t_stream();
    tick(1'b0, 1'b1, 5, '0, '0);
    idle();
    tick(1'b0, 1'b1, 12, '0, '0);
    chk("R6 A words0-1", 1'b1, model[5][0], model[5][1]);
    idle();
    chk("R6 A words2-3", 1'b1, model[5][2], model[5][3]);
    idle();
    chk("R6 B words0-1", 1'b1, model[12][0], model[12][1]);
    idle();
    chk("R6 B words2-3", 1'b1, model[12][2], model[12][3]);
    idle();
    chk("R6 end", 1'b0, '0, '0);
  endtask

  task automatic t_overlap();
    // write one edge after a read
    tick(1'b0, 1'b1, 5, '0, '0);
    tick(1'b1, 1'b0, 20, pat(20, 0, 4), pat(20, 1, 4));
    tick(1'b1, 1'b1, 0, pat(20, 2, 4), pat(20, 3, 4));
    chk("R7 read under write words0-1", 1'b1, model[5][0], model[5][1]);
    for (int w = 0; w < 4; w++) model[20][w] = pat(20, w, 4);
    idle();
    chk("R7 read under write words2-3", 1'b1, model[5][2], model[5][3]);
    idle();
    read_blk(20, "R7 write after read");
    // read one edge after a write
    tick(1'b1, 1'b0, 21, pat(21, 0, 5), pat(21, 1, 5));
    tick(1'b0, 1'b1, 9, pat(21, 2, 5), pat(21, 3, 5));
    for (int w = 0; w < 4; w++) model[21][w] = pat(21, w, 5);
    idle();
    idle();
    chk("R7 read after write words0-1", 1'b1, model[9][0], model[9][1]);
    idle();
    chk("R7 read after write words2-3", 1'b1, model[9][2], model[9][3]);
    idle();
    read_blk(21, "R7 write before read");
  endtask

  task automatic t_collide();
    logic [DW-1:0] old [4];
    // same edge: entirely old data
    for (int w = 0; w < 4; w++) old[w] = model[5][w];
    tick(1'b0, 1'b0, 5, pat(5, 0, 6), pat(5, 1, 6));
    tick(1'b1, 1'b1, 0, pat(5, 2, 6), pat(5, 3, 6));
    idle();
    chk("R8 same edge words0-1 old", 1'b1, old[0], old[1]);
    idle();
    chk("R8 same edge words2-3 old", 1'b1, old[2], old[3]);
    for (int w = 0; w < 4; w++) model[5][w] = pat(5, w, 6);
    idle();
    read_blk(5, "R8 new data after same-edge write");
    // write one edge before the read: words 0-1 new, 2-3 old
    for (int w = 0; w < 4; w++) old[w] = model[9][w];
    tick(1'b1, 1'b0, 9, pat(9, 0, 7), pat(9, 1, 7));
    tick(1'b0, 1'b1, 9, pat(9, 2, 7), pat(9, 3, 7));
    idle();
    idle();
    chk("R8 staggered words0-1 new", 1'b1, pat(9, 0, 7), pat(9, 1, 7));
    idle();
    chk("R8 staggered words2-3 old", 1'b1, old[2], old[3]);
    for (int w = 0; w < 4; w++) model[9][w] = pat(9, w, 7);
    idle();
    read_blk(9, "R8 new data after staggered write");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_wr_gap();
    t_rd_gap();
    t_stream();
    t_overlap();
    t_collide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule